// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns bring-up and periodic refresh for a 512-row dynamic RAM that has an internal row counter. After reset it stays off the memory bus for a power-up pause, then asks for the bus and runs a fixed burst of warm-up refresh cycles. Only after the last of these completes does it raise its ready flag, which tells the rest of the memory subsystem that normal accesses may begin.

Once ready, an interval timer adds one owed refresh to a small backlog counter at the average refresh rate. Each refresh needs one slot: 512 rows in 8 ms gives one slot about every 15.6 us. While the backlog is non-zero the block requests the bus. When the access controller grants it, the block drives a refresh in which the column strobes fall before the row strobe. In that form the device supplies the row address itself, so no address is driven. An urgent flag warns the controller when too many refreshes are owed.

All timing values are clock-cycle counts given as parameters. The defaults suit a 100 MHz clock.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is high, req, ready and urgent are 0, and every strobe output (ras_n, lcas_n, ucas_n, we_n, oe_n) is 1.
- R2: req first rises exactly PAUSE_CYC clock cycles after reset is released. No strobe goes low before that.
- R3: Before ready rises, exactly WARMUP_CNT refresh cycles are performed. ready rises exactly T_RP cycles after ras_n rises at the end of the last of them, and it then stays 1 until reset.
- R4: In every refresh, lcas_n and ucas_n are equal at all times. Both are low for exactly T_CSR cycles before ras_n falls. Both stay low for as long as ras_n is low, and they return high in the same cycle as ras_n.
- R5: ras_n stays low for exactly T_RAS cycles. Before the column strobes fall, ras_n has been high for at least T_RPC cycles. Between two low periods, ras_n stays high for at least T_RP+T_RPC+T_CSR cycles.
- R6: we_n and oe_n are 1 in every cycle.
- R7: Whenever gnt is low, ras_n, lcas_n and ucas_n are all 1. A refresh starts only in a cycle where both req and gnt are high.
- R8: Once ready, the backlog gains one every INTERVAL_CYC cycles, the first gain coming INTERVAL_CYC cycles after ready rises. It loses one T_RP cycles after each refresh's ras_n rise. A gain and a loss in the same cycle cancel. req equals (backlog != 0).
- R9: The backlog saturates at 2^BL_W - 1, so a gain at that value is dropped.
- R10: urgent is 1 exactly when the backlog is greater than URGENT_LIMIT.
- R11: Once a refresh has begun, it runs to completion with req held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gnt | input | 1 | Bus granted by the access controller |
| req | output | 1 | Bus wanted for refresh |
| ready | output | 1 | Power-up sequence finished |
| urgent | output | 1 | Backlog above limit |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |

## Verification
The properties assume the controller asserts gnt only in answer to req. They also assume that gnt stays high until req has dropped, and that the controller leaves the strobes idle before granting. The bench grant driver follows exactly that handshake. It answers each request after a random delay of zero to three cycles and releases only after seeing req low. A directed stretch withholds grants across many timer periods, so the backlog passes the urgent limit and saturates, and is then drained.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_WARM,
        PH_RUN
    } phase_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_CSR,
        ST_RASL,
        ST_RP
    } strobe_st_t;

    typedef struct packed {
        logic ras_n;
        logic lcas_n;
        logic ucas_n;
        logic we_n;
        logic oe_n;
    } strobes_t;

    localparam strobes_t STROBES_IDLE = '{ras_n: 1'b1, lcas_n: 1'b1, ucas_n: 1'b1,
                                          we_n: 1'b1, oe_n: 1'b1};

    // Bits needed to hold values 0..n
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/refseq_init.sv
module refseq_init
    import refseq_pkg::*;
#(
    parameter int PAUSE_CYC  = 20000,
    parameter int WARMUP_CNT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic done,
    output logic warm_pend,
    output logic ready
);
    localparam int PW = cnt_w(PAUSE_CYC);
    localparam int WW = cnt_w(WARMUP_CNT);

    phase_t        phase;
    logic [PW-1:0] pause_cnt;
    logic [WW-1:0] warm_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_PAUSE;
            pause_cnt <= PW'(PAUSE_CYC - 1);
            warm_left <= WW'(WARMUP_CNT);
        end else begin
            unique case (phase)
                PH_PAUSE: begin
                    if (pause_cnt == '0) phase <= PH_WARM;
                    else                 pause_cnt <= pause_cnt - 1'b1;
                end
                PH_WARM: begin
                    if (done) begin
                        warm_left <= warm_left - 1'b1;
                        if (warm_left == WW'(1)) phase <= PH_RUN;
                    end
                end
                default: ;
            endcase
        end
    end

    assign warm_pend = (phase == PH_WARM);
    assign ready     = (phase == PH_RUN);

endmodule

// File: rtl/refseq_timer.sv
module refseq_timer
    import refseq_pkg::*;
#(
    parameter int INTERVAL_CYC = 1562
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int TW = cnt_w(INTERVAL_CYC);
    localparam logic [TW-1:0] RELOAD = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)      cnt <= RELOAD;
        else if (cnt == '0)  cnt <= RELOAD;
        else                 cnt <= cnt - 1'b1;
    end

    assign tick = en && (cnt == '0);

endmodule

// File: rtl/refseq_backlog.sv
module refseq_backlog #(
    parameter int BL_W         = 3,
    parameter int URGENT_LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic pending,
    output logic urgent
);
    localparam logic [BL_W-1:0] FULL = '1;

    logic [BL_W-1:0] owed;

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= '0;
        end else if (inc && !dec) begin
            if (owed != FULL) owed <= owed + 1'b1;
        end else if (dec && !inc) begin
            owed <= owed - 1'b1;
        end
    end

    assign pending = (owed != '0);
    assign urgent  = (32'(owed) > 32'(URGENT_LIMIT));

endmodule

// File: rtl/refseq_strobe.sv
module refseq_strobe
    import refseq_pkg::*;
#(
    parameter int T_RPC = 1,
    parameter int T_CSR = 1,
    parameter int T_RAS = 4,
    parameter int T_RP  = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     want,
    input  logic     gnt,
    output strobes_t pins,
    output logic     done
);
    localparam int LONGEST = max4(T_RPC, T_CSR, T_RAS, T_RP);
    localparam int CW      = cnt_w(LONGEST);

    strobe_st_t    st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (want && gnt) begin
                        st  <= ST_PRE;
                        cnt <= CW'(T_RPC - 1);
                    end
                end
                ST_PRE: begin
                    if (cnt == '0) begin
                        st  <= ST_CSR;
                        cnt <= CW'(T_CSR - 1);
                    end else cnt <= cnt - 1'b1;
                end
                ST_CSR: begin
                    if (cnt == '0) begin
                        st  <= ST_RASL;
                        cnt <= CW'(T_RAS - 1);
                    end else cnt <= cnt - 1'b1;
                end
                ST_RASL: begin
                    if (cnt == '0) begin
                        st  <= ST_RP;
                        cnt <= CW'(T_RP - 1);
                    end else cnt <= cnt - 1'b1;
                end
                ST_RP: begin
                    if (cnt == '0) st <= ST_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        pins = STROBES_IDLE;
        if (st == ST_CSR || st == ST_RASL) begin
            pins.lcas_n = 1'b0;
            pins.ucas_n = 1'b0;
        end
        if (st == ST_RASL) pins.ras_n = 1'b0;
    end

    assign done = (st == ST_RP) && (cnt == '0);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import refseq_pkg::*;
#(
    parameter int CLK_MHZ      = 100,
    parameter int PAUSE_CYC    = CLK_MHZ * 200,
    parameter int INTERVAL_CYC = (CLK_MHZ * 15625) / 1000,
    parameter int WARMUP_CNT   = 8,
    parameter int T_RPC        = 1,
    parameter int T_CSR        = 1,
    parameter int T_RAS        = 4,
    parameter int T_RP         = 2,
    parameter int BL_W         = 3,
    parameter int URGENT_LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic gnt,
    output logic req,
    output logic ready,
    output logic urgent,
    output logic ras_n,
    output logic lcas_n,
    output logic ucas_n,
    output logic we_n,
    output logic oe_n
);
    logic     done;
    logic     warm_pend;
    logic     tick;
    logic     pending;
    strobes_t pins;

    refseq_init #(
        .PAUSE_CYC  (PAUSE_CYC),
        .WARMUP_CNT (WARMUP_CNT)
    ) u_init (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .warm_pend (warm_pend),
        .ready     (ready)
    );

    refseq_timer #(
        .INTERVAL_CYC (INTERVAL_CYC)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .en   (ready),
        .tick (tick)
    );

    refseq_backlog #(
        .BL_W         (BL_W),
        .URGENT_LIMIT (URGENT_LIMIT)
    ) u_backlog (
        .clk     (clk),
        .rst     (rst),
        .inc     (tick),
        .dec     (done && ready),
        .pending (pending),
        .urgent  (urgent)
    );

    assign req = warm_pend || pending;

    refseq_strobe #(
        .T_RPC (T_RPC),
        .T_CSR (T_CSR),
        .T_RAS (T_RAS),
        .T_RP  (T_RP)
    ) u_strobe (
        .clk  (clk),
        .rst  (rst),
        .want (req),
        .gnt  (gnt),
        .pins (pins),
        .done (done)
    );

    assign ras_n  = pins.ras_n;
    assign lcas_n = pins.lcas_n;
    assign ucas_n = pins.ucas_n;
    assign we_n   = pins.we_n;
    assign oe_n   = pins.oe_n;

endmodule

// File: rtl/refseq_chk.sv
module refseq_chk (
    input logic clk,
    input logic rst,
    input logic gnt,
    input logic req,
    input logic ready,
    input logic urgent,
    input logic ras_n,
    input logic lcas_n,
    input logic ucas_n,
    input logic we_n,
    input logic oe_n
);
    // R4: column strobes already low in the cycle before the row strobe falls
    a_r4_cas_before_ras: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!lcas_n && !ucas_n && $past(!lcas_n) && $past(!ucas_n)));

    // R4: both column strobes move together
    a_r4_cas_pair: assert property (@(posedge clk) disable iff (rst)
        lcas_n == ucas_n);

    // R4: column strobes held low while the row strobe is low
    a_r4_cas_held: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> (!lcas_n && !ucas_n));

    // R5: column strobes fall only while the row strobe has been high
    a_r5_cas_after_precharge: assert property (@(posedge clk) disable iff (rst)
        $fell(lcas_n) |-> (ras_n && $past(ras_n)));

    // R6: write and output enables never asserted
    a_r6_we_oe_high: assert property (@(posedge clk) disable iff (rst)
        we_n && oe_n);

    // R7: bus untouched without grant
    a_r7_idle_without_grant: assert property (@(posedge clk) disable iff (rst)
        !gnt |-> (ras_n && lcas_n && ucas_n));

    // R3: ready is sticky and rises with the request cleared
    a_r3_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(ready) |-> ready);
    a_r3_ready_clears_req: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> !req);

    // R10: urgent implies refreshes owed
    a_r10_urgent_req: assert property (@(posedge clk) disable iff (rst)
        urgent |-> req);

    // R11: request held for the whole refresh cycle
    a_r11_req_in_cycle: assert property (@(posedge clk) disable iff (rst)
        (!ras_n || !lcas_n) |-> req);

endmodule

bind dram_refresh_seq refseq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .gnt    (gnt),
    .req    (req),
    .ready  (ready),
    .urgent (urgent),
    .ras_n  (ras_n),
    .lcas_n (lcas_n),
    .ucas_n (ucas_n),
    .we_n   (we_n),
    .oe_n   (oe_n)
);

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;

    localparam int PAUSE    = 50;
    localparam int INTERVAL = 40;
    localparam int WARMUP   = 8;
    localparam int T_RPC    = 2;
    localparam int T_CSR    = 1;
    localparam int T_RAS    = 4;
    localparam int T_RP     = 3;
    localparam int BL_W     = 3;
    localparam int LIMIT    = 3;
    localparam int BL_MAX   = (1 << BL_W) - 1;

    logic clk = 1'b0;
    logic rst;
    logic gnt;
    logic req, ready, urgent, ras_n, lcas_n, ucas_n, we_n, oe_n;

    always #5 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC    (PAUSE),
        .INTERVAL_CYC (INTERVAL),
        .WARMUP_CNT   (WARMUP),
        .T_RPC        (T_RPC),
        .T_CSR        (T_CSR),
        .T_RAS        (T_RAS),
        .T_RP         (T_RP),
        .BL_W         (BL_W),
        .URGENT_LIMIT (LIMIT)
    ) u0 (
        .clk    (clk),
        .rst    (rst),
        .gnt    (gnt),
        .req    (req),
        .ready  (ready),
        .urgent (urgent),
        .ras_n  (ras_n),
        .lcas_n (lcas_n),
        .ucas_n (ucas_n),
        .we_n   (we_n),
        .oe_n   (oe_n)
    );

    int  checks = 0;
    int  errors = 0;
    bit  grant_en = 1'b1;
    bit  sat_seen = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_step(input int bl, input bit inc, input bit dec);
        if (inc && !dec) return (bl == BL_MAX) ? bl : bl + 1;
        if (dec && !inc) return bl - 1;
        return bl;
    endfunction

    // Grant driver: random answer delay, release after req drops
    initial begin
        int gdly;
        gnt  = 1'b0;
        gdly = 0;
        forever begin
            @(negedge clk);
            #1;
            if (rst) begin
                gnt = 1'b0;
            end else if (gnt) begin
                if (!req) gnt = 1'b0;
            end else if (req && grant_en) begin
                if (gdly == 0) gnt = 1'b1;
                else gdly--;
            end else begin
                gdly = $urandom_range(0, 3);
            end
        end
    end

    // Monitor and reference model
    int  n = 0;
    int  ras_hi = 0, ras_lo = 0, cas_lo = 0;
    int  t_rise = -100;
    int  r_at = -1;
    int  warm_seen = 0;
    int  bl = 0;
    bit  ras_p = 1'b1, cas_p = 1'b1, ready_p = 1'b0, req_seen = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            n++;
            check(we_n && oe_n, "R6 we_n/oe_n", {we_n, oe_n}, 3);
            check(lcas_n == ucas_n, "R4 cas pair", {lcas_n, ucas_n}, 0);
            if (!gnt) check(ras_n && lcas_n && ucas_n, "R7 idle without gnt",
                            {ras_n, lcas_n, ucas_n}, 7);
            if (!ras_n || !lcas_n) check(req, "R11 req in cycle", req, 1);
            if (!ras_n) check(!lcas_n, "R4 cas held", lcas_n, 0);

            if (!req_seen) begin
                check(ras_n && lcas_n, "R2 quiet during pause", {ras_n, lcas_n}, 3);
                if (req) begin
                    check(n == PAUSE, "R2 pause length", n, PAUSE);
                    req_seen = 1'b1;
                end
            end

            if (cas_p && !lcas_n)
                check(ras_n && ras_hi >= T_RPC, "R5 precharge before cas", ras_hi, T_RPC);
            if (ras_p && !ras_n) begin
                check(cas_lo == T_CSR, "R4 cas setup", cas_lo, T_CSR);
                check(ras_hi >= T_RP + T_RPC + T_CSR, "R5 ras high time",
                      ras_hi, T_RP + T_RPC + T_CSR);
                if (!ready) warm_seen++;
            end
            if (!ras_p && ras_n) begin
                check(ras_lo == T_RAS, "R5 ras low width", ras_lo, T_RAS);
                check(lcas_n, "R4 cas rises with ras", lcas_n, 1);
                t_rise = n;
            end

            if (!ready_p && ready) begin
                check(warm_seen == WARMUP, "R3 warm-up count", warm_seen, WARMUP);
                check(n == t_rise + T_RP, "R3 ready timing", n, t_rise + T_RP);
                check(!req, "R3 req low at ready", req, 0);
                r_at = n;
            end
            if (ready_p) check(ready, "R3 ready sticky", ready, 1);

            if (r_at >= 0 && n > r_at) begin
                bit inc, dec;
                inc = ((n - r_at) % INTERVAL) == 0;
                dec = (n == t_rise + T_RP);
                if (inc && !dec && bl == BL_MAX) sat_seen = 1'b1;
                bl = model_step(bl, inc, dec);
                if (sat_seen) check(req == (bl != 0), "R9 req vs saturated backlog", req, bl != 0);
                else          check(req == (bl != 0), "R8 req vs backlog", req, bl != 0);
                check(urgent == (bl > LIMIT), "R10 urgent", urgent, bl > LIMIT);
            end

            if (ras_n) begin ras_hi++; ras_lo = 0; end
            else       begin ras_lo++; ras_hi = 0; end
            if (!lcas_n) cas_lo++; else cas_lo = 0;
            ras_p   = ras_n;
            cas_p   = lcas_n;
            ready_p = ready;
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!req && !ready && !urgent, "R1 reset flags", {req, ready, urgent}, 0);
        check(ras_n && lcas_n && ucas_n && we_n && oe_n, "R1 reset strobes",
              {ras_n, lcas_n, ucas_n, we_n, oe_n}, 31);
        #1 rst = 1'b0;

        while (!ready) @(negedge clk);
        repeat (5 * INTERVAL) @(negedge clk);

        // Hold off grants so the backlog passes the limit and saturates (R9, R10)
        while (req || gnt) @(negedge clk);
        #2 grant_en = 1'b0;
        repeat (12 * INTERVAL) @(negedge clk);
        check(urgent, "R10 urgent after hold-off", urgent, 1);
        check(sat_seen, "R9 saturation reached", sat_seen, 1);
        #2 grant_en = 1'b1;
        repeat (10 * INTERVAL) @(negedge clk);
        check(!urgent, "R10 urgent cleared after drain", urgent, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule